// File: doc/BRIEF.md
# Supervoltage-Mode Flash Array Controller

This block is the control logic for a byte-wide flash array that can be reprogrammed many times. It sits beside a small on-chip storage array that stands in for the flash cells. It samples active-low chip-enable, output-enable and write-enable pins on a system clock. It also samples two flags that report a programming supervoltage, one on the output-enable pin and one on address line 9. From these it decides what to do. There are no command cycles. The pin levels alone select standby, output disable, read, identification, byte program or whole-chip erase.

Programming can only clear bits, because the new byte is ANDed into the stored byte. The only way back to ones is a whole-chip erase. The erase walks the array one address per clock and holds a busy flag until the walk ends.

A density parameter (0 to 3) selects the device identification byte and sets the address bus width to 16 + density bits. A separate parameter sets how many low address bits the stand-in array decodes.

Top module: `mtp_array_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `dout_en` is 0, `dout` is 00h and `busy` is 0.
- R2: `dout_en` goes to 0 on the clock after any of these: chip enable high, output enable high, supervoltage flag on output enable set, or `busy` high. In any other case it goes to 1 on the following clock.
- R3: With chip enable low, output enable low and no supervoltage flag, `dout` shows the stored byte at the low `MEM_AW` address bits one clock later.
- R4: A falling edge of `we_n` while chip enable is low, the output-enable supervoltage flag is set and the address-9 flag is clear replaces the addressed byte with (stored AND `din`). A bit can never be set this way.
- R5: A falling edge of `we_n` while chip enable is low and both supervoltage flags are set starts a whole-array erase. `busy` is 1 on the next cycle, and after the erase every byte reads FFh.
- R6: In identification mode (chip enable low, output enable low, address-9 flag set, output-enable flag clear), with address bits above bit 0 all zero, address bit 0 = 0 returns the manufacturer byte BFh one clock later.
- R7: In identification mode with address bit 0 = 1 and all higher bits zero, the device byte is returned: C4h, C5h, C6h or C2h for density 0, 1, 2 or 3. If any bit above bit 0 is set, the output is 00h.
- R8: A falling edge of `we_n` without the output-enable supervoltage flag leaves the array unchanged. Holding `we_n` low while `din` changes programs only once, at the edge.
- R9: `busy` stays high for exactly 2^MEM_AW cycles. Program and erase requests that arrive while it is high have no effect on the array.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low; its falling edge triggers program or erase |
| oe_hv | input | 1 | Supervoltage present on the output-enable pin |
| a9_hv | input | 1 | Supervoltage present on address line 9 |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Program data |
| dout | output | 8 | Read or identification data |
| dout_en | output | 1 | Enable for the external tristate data driver |
| busy | output | 1 | Erase walk in progress |

## Verification
The bench programs the same address twice with overlapping patterns. A design that wrote `din` directly, instead of ANDing it into the stored byte, would read back the second pattern instead of the intersection. It holds `we_n` low across a change of `din` and pulses `we_n` without the programming flag. A level-triggered or ungated write would then corrupt bytes that must stay intact.

During an erase walk it issues a program to an address the walk has already passed. A design that did not block requests while busy would leave that byte at 00h rather than FFh. It also counts the busy cycles, which catches an off-by-one in the walk length. Identification reads cover both address-0 values, a nonzero upper address, and a second instance at the largest density, so a wrong device table or a missing upper-bit check shows as a wrong byte.

// File: rtl/mtp_pkg.sv
// Shared types and constants for the supervoltage-mode flash controller.
// Assumes density codes 0..3; any larger code maps to the largest part.
package mtp_pkg;

    typedef enum logic [2:0] {
        MD_STANDBY,
        MD_OUT_OFF,
        MD_READ,
        MD_IDENT,
        MD_PROGRAM,
        MD_ERASE
    } mtp_mode_t;

    localparam logic [7:0] MANUF_CODE = 8'hBF;
    localparam logic [7:0] ERASED     = 8'hFF;

    // Device identification byte for a density code.
    function automatic logic [7:0] dev_code(input int density);
        case (density)
            0:       return 8'hC4;
            1:       return 8'hC5;
            2:       return 8'hC6;
            default: return 8'hC2;
        endcase
    endfunction

endpackage

// File: rtl/mtp_mode_dec.sv
// Decodes the pin levels and supervoltage flags into one operating mode.
// Purely combinational. Priority: deselect, then the supervoltage modes,
// then output disable, then identification over read.
module mtp_mode_dec
    import mtp_pkg::*;
(
    input  logic      ce_n,
    input  logic      oe_n,
    input  logic      oe_hv,
    input  logic      a9_hv,
    output mtp_mode_t mode
);

    // Mode priority decode.
    always_comb begin
        if (ce_n)
            mode = MD_STANDBY;
        else if (oe_hv && a9_hv)
            mode = MD_ERASE;
        else if (oe_hv)
            mode = MD_PROGRAM;
        else if (oe_n)
            mode = MD_OUT_OFF;
        else if (a9_hv)
            mode = MD_IDENT;
        else
            mode = MD_READ;
    end

endmodule

// File: rtl/mtp_cell_array.sv
// Stand-in storage for the flash cells: one write port and one
// combinational read port. The contents are not reset; an erase is the
// only defined way to initialise them.
module mtp_cell_array #(
    parameter int DW = 8,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [DEPTH];

    // Write port.
    always_ff @(posedge clk) begin
        if (wr_en)
            cells[wr_addr] <= wr_data;
    end

    // Read port.
    always_comb rd_data = cells[rd_addr];

endmodule

// File: rtl/mtp_erase_seq.sv
// Walks every array address once, one address per clock, after a start
// pulse. Busy is high for exactly 2^AW cycles. Starts that arrive while
// busy are ignored.
module mtp_erase_seq #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    output logic          busy,
    output logic [AW-1:0] sweep_addr
);

    localparam logic [AW-1:0] LAST = '1;

    // Walk counter and busy flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy       <= 1'b0;
            sweep_addr <= '0;
        end else if (busy) begin
            sweep_addr <= sweep_addr + 1'b1;
            if (sweep_addr == LAST)
                busy <= 1'b0;
        end else if (start) begin
            busy       <= 1'b1;
            sweep_addr <= '0;
        end
    end

endmodule

// File: rtl/mtp_array_ctrl.sv
// Controller for a byte-wide reprogrammable flash array. The mode comes
// from pin levels and two supervoltage flags. Program ANDs data into the
// stored byte. Erase walks the whole array to FFh. Identification
// returns fixed bytes. Outputs are registered: one clock from pins to
// dout/dout_en. Assumes MEM_AW <= ADDR_W and that oe_hv is only set while
// oe_n is high.
module mtp_array_ctrl
    import mtp_pkg::*;
#(
    parameter int DENSITY = 0,
    parameter int ADDR_W  = 16 + DENSITY,
    parameter int MEM_AW  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              oe_hv,
    input  logic              a9_hv,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    output logic [7:0]        dout,
    output logic              dout_en,
    output logic              busy
);

    localparam logic [7:0] DEV_CODE = dev_code(DENSITY);

    mtp_mode_t         mode;
    logic              we_q;
    logic              we_fall;
    logic              prog_go;
    logic              erase_go;
    logic [MEM_AW-1:0] sweep_addr;
    logic              mem_we;
    logic [MEM_AW-1:0] mem_waddr;
    logic [7:0]        mem_wdata;
    logic [7:0]        mem_rdata;
    logic [7:0]        id_byte;

    mtp_mode_dec u_dec (
        .ce_n  (ce_n),
        .oe_n  (oe_n),
        .oe_hv (oe_hv),
        .a9_hv (a9_hv),
        .mode  (mode)
    );

    // Registered copy of write enable for falling-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n)
            we_q <= 1'b1;
        else
            we_q <= we_n;
    end

    // A falling edge is accepted only while idle.
    always_comb begin
        we_fall  = we_q && !we_n;
        prog_go  = we_fall && !busy && (mode == MD_PROGRAM);
        erase_go = we_fall && !busy && (mode == MD_ERASE);
    end

    mtp_erase_seq #(.AW(MEM_AW)) u_sweep (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (erase_go),
        .busy       (busy),
        .sweep_addr (sweep_addr)
    );

    // Write-port mux: erase fill while busy, else AND-program.
    always_comb begin
        mem_we    = busy || prog_go;
        mem_waddr = busy ? sweep_addr : addr[MEM_AW-1:0];
        mem_wdata = busy ? ERASED : (mem_rdata & din);
    end

    mtp_cell_array #(.DW(8), .AW(MEM_AW)) u_cells (
        .clk     (clk),
        .wr_en   (mem_we),
        .wr_addr (mem_waddr),
        .wr_data (mem_wdata),
        .rd_addr (addr[MEM_AW-1:0]),
        .rd_data (mem_rdata)
    );

    // Identification byte select.
    always_comb begin
        if (addr[ADDR_W-1:1] != '0)
            id_byte = 8'h00;
        else if (addr[0])
            id_byte = DEV_CODE;
        else
            id_byte = MANUF_CODE;
    end

    // Registered output data and driver enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout    <= 8'h00;
            dout_en <= 1'b0;
        end else if (busy) begin
            dout    <= 8'h00;
            dout_en <= 1'b0;
        end else if (mode == MD_READ) begin
            dout    <= mem_rdata;
            dout_en <= 1'b1;
        end else if (mode == MD_IDENT) begin
            dout    <= id_byte;
            dout_en <= 1'b1;
        end else begin
            dout    <= 8'h00;
            dout_en <= 1'b0;
        end
    end

endmodule

// File: rtl/mtp_array_ctrl_chk.sv
// Assertion checker bound to mtp_array_ctrl. It watches only the ports
// and keeps its own write-enable copy and busy-length counter.
module mtp_array_ctrl_chk #(
    parameter int ADDR_W = 16,
    parameter int MEM_AW = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ce_n,
    input logic              oe_n,
    input logic              we_n,
    input logic              oe_hv,
    input logic              a9_hv,
    input logic [ADDR_W-1:0] addr,
    input logic [7:0]        dout,
    input logic              dout_en,
    input logic              busy
);

    localparam int DEPTH = 1 << MEM_AW;
    localparam int CW    = MEM_AW + 2;

    logic          we_seen;
    logic [CW-1:0] busy_cnt;

    // Own copy of write enable, for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) we_seen <= 1'b1;
        else        we_seen <= we_n;
    end

    // Counts consecutive busy cycles.
    always_ff @(posedge clk) begin
        if (!rst_n)    busy_cnt <= '0;
        else if (busy) busy_cnt <= busy_cnt + 1'b1;
        else           busy_cnt <= '0;
    end

    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> (!dout_en && !busy)); // R1
    AST_DESELECT_HIZ: assert property (@(posedge clk) disable iff (!rst_n) (ce_n || oe_n || oe_hv) |=> !dout_en); // R2
    AST_BUSY_HIZ: assert property (@(posedge clk) disable iff (!rst_n) busy |-> !dout_en); // R2
    AST_ERASE_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (we_seen && !we_n && !ce_n && oe_hv && a9_hv && !busy) |=> busy); // R5
    AST_MANUF_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !oe_n && !oe_hv && a9_hv && !busy && addr == '0) |=> (dout_en && dout == 8'hBF)); // R6
    AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_cnt == CW'(DEPTH))); // R9

endmodule

bind mtp_array_ctrl mtp_array_ctrl_chk #(.ADDR_W(ADDR_W), .MEM_AW(MEM_AW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ce_n    (ce_n),
    .oe_n    (oe_n),
    .we_n    (we_n),
    .oe_hv   (oe_hv),
    .a9_hv   (a9_hv),
    .addr    (addr),
    .dout    (dout),
    .dout_en (dout_en),
    .busy    (busy)
);

// File: tb/mtp_array_ctrl_bench.sv
// Self-checking bench for mtp_array_ctrl: a program/read vector table
// walked by one loop, then directed tests for reset and corner cases.
module mtp_array_ctrl_bench;

    localparam int MEM_AW = 8;
    localparam int DEPTH  = 1 << MEM_AW;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, oe_hv = 1'b0, a9_hv = 1'b0;
    logic [15:0] addr = '0;
    logic [7:0]  din = '0;
    logic [7:0]  dout;
    logic        dout_en, busy;

    logic [18:0] addr3 = '0;
    logic [7:0]  dout3;
    logic        dout_en3, busy3;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    mtp_array_ctrl #(.DENSITY(0), .MEM_AW(MEM_AW)) u_mtp_array_ctrl (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .oe_hv(oe_hv), .a9_hv(a9_hv), .addr(addr), .din(din),
        .dout(dout), .dout_en(dout_en), .busy(busy)
    );

    // Largest density: identification byte and address width only.
    mtp_array_ctrl #(.DENSITY(3), .MEM_AW(MEM_AW)) u_mtp_array_ctrl_d3 (
        .clk(clk), .rst_n(rst_n), .ce_n(1'b0), .oe_n(1'b0), .we_n(1'b1),
        .oe_hv(1'b0), .a9_hv(1'b1), .addr(addr3), .din(8'h00),
        .dout(dout3), .dout_en(dout_en3), .busy(busy3)
    );

    // Vectors: {address, program data, expected read-back}.
    localparam int NVEC = 7;
    localparam logic [23:0] VEC [NVEC] = '{
        {8'd10,  8'hF0, 8'hF0},
        {8'd10,  8'h3C, 8'h30},
        {8'd10,  8'hFF, 8'h30},
        {8'd255, 8'hA5, 8'hA5},
        {8'd0,   8'h00, 8'h00},
        {8'd1,   8'hFF, 8'hFF},
        {8'd77,  8'h5A, 8'h5A}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic set_pins(input logic c, input logic o, input logic w,
                            input logic ohv, input logic ahv, input logic [15:0] a);
        ce_n = c; oe_n = o; we_n = w; oe_hv = ohv; a9_hv = ahv; addr = a;
    endtask

    task automatic do_read(input logic [15:0] a, input logic ahv,
                           output logic [7:0] d, output logic en);
        @(negedge clk);
        set_pins(1'b0, 1'b0, 1'b1, 1'b0, ahv, a);
        @(negedge clk);
        d = dout; en = dout_en;
    endtask

    task automatic do_prog(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        set_pins(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, a);
        din = d;
        @(negedge clk) we_n = 1'b0;
        @(negedge clk) we_n = 1'b1;
        @(negedge clk) oe_hv = 1'b0;
    endtask

    task automatic erase_start();
        @(negedge clk);
        set_pins(1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 16'h0000);
        @(negedge clk) we_n = 1'b0;
        @(negedge clk);
        we_n = 1'b1; oe_hv = 1'b0; a9_hv = 1'b0; oe_n = 1'b1;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual hung expected done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        logic [7:0] d;
        logic       en;
        int         n;

        // R1: reset state.
        repeat (3) @(negedge clk);
        check("R1 dout_en in reset", dout_en, 0);
        check("R1 busy in reset", busy, 0);
        check("R1 dout in reset", dout, 8'h00);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 dout_en after reset", dout_en, 0);

        // R5/R9: clean erase, count busy cycles.
        erase_start();
        n = 0;
        while (busy) begin n++; @(negedge clk); end
        check("R9 busy length", n, DEPTH);
        do_read(16'd0, 1'b0, d, en);   check("R5 erased byte 0", d, 8'hFF);
        do_read(16'd128, 1'b0, d, en); check("R5 erased byte 128", d, 8'hFF);
        do_read(16'd255, 1'b0, d, en); check("R5 erased byte 255", d, 8'hFF);
        check("R3 read drives bus", en, 1);

        // R3/R4: vector table of program then read-back.
        for (int i = 0; i < NVEC; i++) begin
            do_prog({8'h00, VEC[i][23:16]}, VEC[i][15:8]);
            do_read({8'h00, VEC[i][23:16]}, 1'b0, d, en);
            check($sformatf("R4 AND program vec %0d", i), d, VEC[i][7:0]);
            check($sformatf("R3 read enable vec %0d", i), en, 1);
        end

        // R8: write-enable edge without the programming flag.
        @(negedge clk);
        set_pins(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 16'd1);
        din = 8'h00;
        @(negedge clk) we_n = 1'b0;
        @(negedge clk) we_n = 1'b1;
        do_read(16'd1, 1'b0, d, en);
        check("R8 inhibit leaves byte", d, 8'hFF);

        // R8: held write enable programs only at the edge.
        @(negedge clk);
        set_pins(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 16'd2);
        din = 8'hF0;
        @(negedge clk) we_n = 1'b0;
        @(negedge clk) din = 8'h0F;
        repeat (2) @(negedge clk);
        we_n = 1'b1; oe_hv = 1'b0;
        do_read(16'd2, 1'b0, d, en);
        check("R8 single program per edge", d, 8'hF0);

        // R2: bus released in standby, output disable and programming mode.
        @(negedge clk) set_pins(1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 16'd2);
        @(negedge clk) check("R2 standby hiz", dout_en, 0);
        @(negedge clk) set_pins(1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 16'd2);
        @(negedge clk) check("R2 output disable hiz", dout_en, 0);
        @(negedge clk) set_pins(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 16'd2);
        @(negedge clk) check("R2 program mode hiz", dout_en, 0);

        // R6/R7: identification bytes.
        do_read(16'h0000, 1'b1, d, en); check("R6 manufacturer byte", d, 8'hBF);
        check("R6 id drives bus", en, 1);
        do_read(16'h0001, 1'b1, d, en); check("R7 device byte density 0", d, 8'hC4);
        do_read(16'h0101, 1'b1, d, en); check("R7 upper bits nonzero", d, 8'h00);
        addr3 = 19'd1;
        @(negedge clk);
        @(negedge clk);
        check("R7 device byte density 3", dout3, 8'hC2);
        addr3 = 19'h40000;
        @(negedge clk);
        @(negedge clk);
        check("R7 density 3 top address bit", dout3, 8'h00);

        // R9/R2: requests during an erase walk are ignored; bus stays off.
        erase_start();
        repeat (40) @(negedge clk);
        set_pins(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 16'd5);
        @(negedge clk);
        @(negedge clk) check("R2 busy hiz", dout_en, 0);
        do_prog(16'd5, 8'h00);
        while (busy) @(negedge clk);
        do_read(16'd5, 1'b0, d, en);  check("R9 program while busy ignored", d, 8'hFF);
        do_read(16'd10, 1'b0, d, en); check("R5 second erase byte 10", d, 8'hFF);
        do_read(16'd2, 1'b0, d, en);  check("R5 second erase byte 2", d, 8'hFF);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule